// File: doc/BRIEF.md
# Multichannel DAC Command Decoder

This block sits behind a serial front end that collects 16-bit command words. When the front end raises its execute strobe for one system-clock cycle, the decoder reads the word and updates a bank of twelve 8-bit converter code registers. It also keeps one high-impedance flag per channel, which the analog output stage uses to release its pin. The low nibble of the word names either one converter channel, a global function, or one of three expander commands. For a channel or a global function, the next nibble is a subcode that selects the action: load a code, float the output, or return everything to its power-up state.

Channels 1 to 4 always drive. Channels 5 to 12 share their pins with a digital expander, so each of them can be floated. The expander commands are not carried out here. The decoder turns them into single-cycle strobes and presents the 12-bit payload with them. The upper byte of a word is a code, and the analog level it sets is that code times the reference divided by 256. Channel count, code width, word layout and the first floatable channel are all parameters.

Top module: `dac_cmd_decoder`

## Requirements
- R1: While reset is asserted and just after it is released, every code register reads 0. The hiz flags of channels 1 to 4 are 0, those of channels 5 to 12 are 1, and all three expander strobes and the payload are 0.
- R2: An executed word with bits [3:0] = 1..12 and subcode bits [7:4] = 4'b0000 loads bits [15:8] (bit 15 the MSB) into that channel on the clock edge that samples the strobe. It also clears that channel's hiz flag. No other channel changes.
- R3: An executed word with bits [3:0] = 5..12 and subcode 4'b0001 sets that channel's hiz flag and leaves its code unchanged.
- R4: Subcode 4'b0001 sent to channels 1 to 4 has no effect. Any subcode other than 4'b0000 and 4'b0001 sent to any channel also has no effect on codes or flags.
- R5: An executed word with bits [3:0] = 0 and subcode 4'b0000 writes bits [15:8] into all twelve code registers and clears every hiz flag.
- R6: Bits [3:0] = 0 with subcode 4'b0001 sets the hiz flags of channels 5 to 12. Channels 1 to 4 and every code register are left unchanged.
- R7: Bits [3:0] = 0 with subcode 4'b0010 restores the state of R1 (all codes 0, and the hiz pattern of R1).
- R8: Bits [3:0] = 0 with any other subcode changes nothing.
- R9: Bits [3:0] = 13 gives a one-cycle expander-write strobe in the cycle after the execute strobe. The payload output then holds bits [15:4], and no channel changes.
- R10: Bits [3:0] = 14 gives the expander-read strobe and bits [3:0] = 15 gives the direction-write strobe, with the same timing and payload as R9. At most one strobe is high at a time.
- R11: A cycle without the execute strobe changes no code, no flag and no payload, and leaves all strobes low.
- R12: Channel n (1-based) occupies ch_code[8n-1:8n-8] and ch_hiz[n-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, power-up state |
| exec_stb | input | 1 | One-cycle execute strobe from the serial front end |
| cmd_word | input | 16 | Command word, valid with exec_stb |
| ch_code | output | 96 | Twelve packed 8-bit converter codes |
| ch_hiz | output | 12 | Per-channel high-impedance flag |
| exp_write_stb | output | 1 | Expander parallel-write command strobe |
| exp_read_stb | output | 1 | Expander parallel-read command strobe |
| dir_write_stb | output | 1 | Pin-direction register write strobe |
| exp_payload | output | 12 | Bits [15:4] of the last expander command |

## Verification
Every result comes from a flop that samples the execute strobe. Codes, hiz flags, strobes and payload therefore all change on the rising edge where exec_stb is high, and each is due exactly one edge after the stimulus is driven. The bench drives a word on a falling edge and compares all outputs against its model on the next falling edge, half a period after the updating edge. It then drives the next word, so each strobe is also confirmed low again in the cycle after its pulse.

// File: rtl/dacd_pkg.sv
package dacd_pkg;

   localparam int unsigned SUB_W = 4;

   localparam logic [SUB_W-1:0] SUB_LOAD  = 4'h0;
   localparam logic [SUB_W-1:0] SUB_FLOAT = 4'h1;
   localparam logic [SUB_W-1:0] SUB_INIT  = 4'h2;

   typedef enum logic [1:0] {
      XP_NONE  = 2'd0,
      XP_WRITE = 2'd1,
      XP_READ  = 2'd2,
      XP_DIR   = 2'd3
   } xp_cmd_e;

endpackage

// File: rtl/dacd_decode.sv
module dacd_decode
   import dacd_pkg::*;
#(
   parameter int unsigned NUM_CH      = 12,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned FIRST_FLOAT = 5
) (
   input  logic              exec_stb,
   input  logic [SEL_W-1:0]  sel,
   input  logic [SUB_W-1:0]  sub,
   output logic [NUM_CH-1:0] load_en,
   output logic [NUM_CH-1:0] float_en,
   output logic [NUM_CH-1:0] init_en,
   output xp_cmd_e           xp_cmd
);

   localparam logic [SEL_W-1:0] SEL_BCAST = '0;
   localparam logic [SEL_W-1:0] SEL_XP_WR = SEL_W'(NUM_CH + 1);
   localparam logic [SEL_W-1:0] SEL_XP_RD = SEL_W'(NUM_CH + 2);
   localparam logic [SEL_W-1:0] SEL_XP_DR = SEL_W'(NUM_CH + 3);

   logic bcast_hit;
   logic sub_load, sub_float, sub_init;

   always_comb begin
      bcast_hit = exec_stb && (sel == SEL_BCAST);
      sub_load  = (sub == SUB_LOAD);
      sub_float = (sub == SUB_FLOAT);
      sub_init  = (sub == SUB_INIT);
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic own_hit;
      assign own_hit    = exec_stb && (sel == SEL_W'(i + 1));
      assign load_en[i] = (own_hit || bcast_hit) && sub_load;
      assign init_en[i] = bcast_hit && sub_init;
      if (i + 1 >= FIRST_FLOAT) begin : g_float
         assign float_en[i] = (own_hit || bcast_hit) && sub_float;
      end else begin : g_fixed
         assign float_en[i] = 1'b0;
      end
   end

   always_comb begin
      xp_cmd = XP_NONE;
      if (exec_stb) begin
         case (sel)
            SEL_XP_WR: xp_cmd = XP_WRITE;
            SEL_XP_RD: xp_cmd = XP_READ;
            SEL_XP_DR: xp_cmd = XP_DIR;
            default:   xp_cmd = XP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/dacd_chan.sv
module dacd_chan #(
   parameter int unsigned CODE_W    = 8,
   parameter bit          FLOATABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              float_en,
   input  logic              init_en,
   input  logic [CODE_W-1:0] data,
   output logic [CODE_W-1:0] code,
   output logic              hiz
);

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (init_en) begin
         code_q <= '0;
      end else if (load_en) begin
         code_q <= data;
      end
   end

   if (FLOATABLE) begin : g_hiz
      logic hiz_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hiz_q <= 1'b1;
         end else if (init_en || float_en) begin
            hiz_q <= 1'b1;
         end else if (load_en) begin
            hiz_q <= 1'b0;
         end
      end
      assign hiz = hiz_q;
   end else begin : g_drive
      assign hiz = 1'b0;
   end

   assign code = code_q;

   // R2
   load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && !init_en |=> (code == $past(data)) && !hiz);

   // R3
   float_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      float_en |=> hiz && $stable(code));

   // R7
   init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_en |=> (code == '0) && (hiz == FLOATABLE));

endmodule

// File: rtl/dacd_xp_port.sv
module dacd_xp_port
   import dacd_pkg::*;
#(
   parameter int unsigned PAY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xp_cmd_e          xp_cmd,
   input  logic [PAY_W-1:0] payload_in,
   output logic             wr_stb,
   output logic             rd_stb,
   output logic             dir_stb,
   output logic [PAY_W-1:0] payload
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         rd_stb  <= 1'b0;
         dir_stb <= 1'b0;
         payload <= '0;
      end else begin
         wr_stb  <= (xp_cmd == XP_WRITE);
         rd_stb  <= (xp_cmd == XP_READ);
         dir_stb <= (xp_cmd == XP_DIR);
         if (xp_cmd != XP_NONE) begin
            payload <= payload_in;
         end
      end
   end

   // R10
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb, rd_stb, dir_stb}));

   // R9
   write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xp_cmd == XP_WRITE |=> wr_stb && (payload == $past(payload_in)));

   // R11
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xp_cmd == XP_NONE |=> !wr_stb && !rd_stb && !dir_stb && $stable(payload));

endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
   import dacd_pkg::*;
#(
   parameter int unsigned NUM_CH      = 12,
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned FIRST_FLOAT = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       exec_stb,
   input  logic [WORD_W-1:0]          cmd_word,
   output logic [NUM_CH*CODE_W-1:0]   ch_code,
   output logic [NUM_CH-1:0]          ch_hiz,
   output logic                       exp_write_stb,
   output logic                       exp_read_stb,
   output logic                       dir_write_stb,
   output logic [WORD_W-SEL_W-1:0]    exp_payload
);

   localparam int unsigned PAY_W = WORD_W - SEL_W;

   if (SEL_W + SUB_W + CODE_W != WORD_W) begin : g_bad_layout
      $error("word width must equal select + subcode + code widths");
   end
   if (NUM_CH + 3 >= (1 << SEL_W)) begin : g_bad_count
      $error("select field too narrow for channel count plus special codes");
   end
   if (FIRST_FLOAT < 1 || FIRST_FLOAT > NUM_CH) begin : g_bad_float
      $error("first floatable channel out of range");
   end

   logic [SEL_W-1:0]  sel;
   logic [SUB_W-1:0]  sub;
   logic [CODE_W-1:0] data;
   logic [NUM_CH-1:0] load_en, float_en, init_en;
   logic [NUM_CH-1:0] float_mask;
   xp_cmd_e           xp_cmd;

   assign sel  = cmd_word[SEL_W-1:0];
   assign sub  = cmd_word[SEL_W +: SUB_W];
   assign data = cmd_word[WORD_W-1 -: CODE_W];

   dacd_decode #(
      .NUM_CH      (NUM_CH),
      .SEL_W       (SEL_W),
      .FIRST_FLOAT (FIRST_FLOAT)
   ) u_decode (
      .exec_stb (exec_stb),
      .sel      (sel),
      .sub      (sub),
      .load_en  (load_en),
      .float_en (float_en),
      .init_en  (init_en),
      .xp_cmd   (xp_cmd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      localparam bit CAN_FLOAT = (i + 1 >= FIRST_FLOAT);
      assign float_mask[i] = CAN_FLOAT;
      dacd_chan #(
         .CODE_W    (CODE_W),
         .FLOATABLE (CAN_FLOAT)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_en  (load_en[i]),
         .float_en (float_en[i]),
         .init_en  (init_en[i]),
         .data     (data),
         .code     (ch_code[i*CODE_W +: CODE_W]),
         .hiz      (ch_hiz[i])
      );
   end

   dacd_xp_port #(
      .PAY_W (PAY_W)
   ) u_xp (
      .clk        (clk),
      .rst_n      (rst_n),
      .xp_cmd     (xp_cmd),
      .payload_in (cmd_word[WORD_W-1:SEL_W]),
      .wr_stb     (exp_write_stb),
      .rd_stb     (exp_read_stb),
      .dir_stb    (dir_write_stb),
      .payload    (exp_payload)
   );

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_stb |=> $stable(ch_code) && $stable(ch_hiz));

   // R7
   global_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb && (sel == '0) && (sub == SUB_INIT)
      |=> (ch_code == '0) && (ch_hiz == float_mask));

   // R5
   broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb && (sel == '0) && (sub == SUB_LOAD) |=> (ch_hiz == '0));

   // R4
   fixed_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hiz & ~float_mask) == '0);

endmodule

// File: tb/dac_cmd_decoder_test.sv
`timescale 1ns/100ps
module dac_cmd_decoder_test;

   localparam int NCH = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_stb = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [95:0] ch_code;
   logic [11:0] ch_hiz;
   logic        exp_write_stb, exp_read_stb, dir_write_stb;
   logic [11:0] exp_payload;

   int vectors = 0;
   int errors  = 0;

   logic [7:0]  code_m [NCH];
   logic [11:0] hiz_m;
   logic [11:0] pay_m;
   logic [2:0]  stb_m;

   always #2.5 clk = ~clk;

   dac_cmd_decoder uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .exec_stb      (exec_stb),
      .cmd_word      (cmd_word),
      .ch_code       (ch_code),
      .ch_hiz        (ch_hiz),
      .exp_write_stb (exp_write_stb),
      .exp_read_stb  (exp_read_stb),
      .dir_write_stb (dir_write_stb),
      .exp_payload   (exp_payload)
   );

   function automatic logic [95:0] packed_codes();
      logic [95:0] p;
      for (int i = 0; i < NCH; i++) p[i*8 +: 8] = code_m[i];
      return p;
   endfunction

   function automatic string req_of(logic [15:0] w, logic ex);
      int s = int'(w[3:0]);
      int u = int'(w[7:4]);
      if (!ex) return "R11";
      if (s >= 1 && s <= 12) begin
         if (u == 0) return "R2";
         if (u == 1 && s >= 5) return "R3";
         return "R4";
      end
      if (s == 0) begin
         if (u == 0) return "R5";
         if (u == 1) return "R6";
         if (u == 2) return "R7";
         return "R8";
      end
      if (s == 13) return "R9";
      return "R10";
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NCH; i++) code_m[i] = 8'h00;
      hiz_m = 12'hFF0;
      pay_m = '0;
      stb_m = '0;
   endtask

   task automatic model_apply(logic [15:0] w, logic ex);
      int s = int'(w[3:0]);
      int u = int'(w[7:4]);
      stb_m = '0;
      if (!ex) return;
      if (s >= 1 && s <= 12) begin
         if (u == 0) begin
            code_m[s-1] = w[15:8];
            hiz_m[s-1]  = 1'b0;
         end else if (u == 1 && s >= 5) begin
            hiz_m[s-1] = 1'b1;
         end
      end else if (s == 0) begin
         if (u == 0) begin
            for (int i = 0; i < NCH; i++) code_m[i] = w[15:8];
            hiz_m = '0;
         end else if (u == 1) begin
            hiz_m = hiz_m | 12'hFF0;
         end else if (u == 2) begin
            for (int i = 0; i < NCH; i++) code_m[i] = 8'h00;
            hiz_m = 12'hFF0;
         end
      end else begin
         pay_m = w[15:4];
         stb_m = (s == 13) ? 3'b001 : (s == 14) ? 3'b010 : 3'b100;
      end
   endtask

   task automatic check_all(string req);
      logic [95:0] ec = packed_codes();
      logic [2:0]  as = {dir_write_stb, exp_read_stb, exp_write_stb};
      vectors++;
      if (ch_code !== ec) begin
         errors++;
         $display("FAIL %s codes: actual %h expected %h", req, ch_code, ec);
      end
      vectors++;
      if (ch_hiz !== hiz_m) begin
         errors++;
         $display("FAIL %s hiz: actual %h expected %h", req, ch_hiz, hiz_m);
      end
      vectors++;
      if (as !== stb_m || exp_payload !== pay_m) begin
         errors++;
         $display("FAIL %s strobes/payload: actual %b/%h expected %b/%h",
                  req, as, exp_payload, stb_m, pay_m);
      end
   endtask

   // drive at a falling edge, result due after the next rising edge
   task automatic step(logic [15:0] w, logic ex);
      cmd_word = w;
      exec_stb = ex;
      model_apply(w, ex);
      @(negedge clk);
      check_all(req_of(w, ex));
   endtask

   task automatic check_slice(int ch, logic [7:0] exp_code, logic exp_hiz);
      vectors++;
      // R12: channel ch at ch_code[8ch-1:8ch-8], flag at ch_hiz[ch-1]
      if (ch_code[(ch-1)*8 +: 8] !== exp_code || ch_hiz[ch-1] !== exp_hiz) begin
         errors++;
         $display("FAIL R12 ch%0d: actual %h/%b expected %h/%b", ch,
                  ch_code[(ch-1)*8 +: 8], ch_hiz[ch-1], exp_code, exp_hiz);
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h0D1A_C5E7);
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // directed corners
      step(16'hA501, 1'b1);          // R2 channel 1
      step(16'h3C0C, 1'b1);          // R2 channel 12 leaves float
      check_slice(1, 8'hA5, 1'b0);
      check_slice(12, 8'h3C, 1'b0);
      step(16'h0011, 1'b1);          // R4 float to channel 1 ignored
      step(16'h001C, 1'b1);          // R3 channel 12 floats, code kept
      step(16'hFF35, 1'b1);          // R4 unknown subcode
      step(16'hFF00, 1'b1);          // R5 broadcast max
      step(16'h0010, 1'b1);          // R6 global float
      step(16'h00F0, 1'b1);          // R8
      step(16'hABCD, 1'b1);          // R9
      step(16'hABCD, 1'b0);          // R11 strobe drops
      step(16'h123E, 1'b1);          // R10 read
      step(16'h456F, 1'b1);          // R10 direction
      step(16'h5500, 1'b0);          // R11 no exec
      step(16'h0020, 1'b1);          // R7 power-up state

      for (int n = 0; n < 2000; n++) begin
         logic [15:0] w;
         logic [3:0]  u;
         u = (($urandom % 5) == 0) ? 4'($urandom) : 4'($urandom % 3);
         w = {8'($urandom), u, 4'($urandom)};
         step(w, (($urandom % 4) != 0));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule